// File: doc/BRIEF.md
# Lockdown-Aware Memory Permission Gate

This block makes the final allow or deny decision for one memory access in a physical memory protection unit. It receives the configuration bits of the entry that an upstream priority and address matcher has already selected: read, write and execute permission, the lock bit, and a flag that says whether any entry matched at all. It also receives the access type, whether the hart is running in machine mode, and two policy bits held elsewhere: a machine-mode lockdown switch and a default-deny switch for accesses that match no entry.

With lockdown off, the gate follows the classic rule. Machine mode is bound only by locked entries, and lower modes are always bound by the entry bits. With lockdown on, some encodings change meaning. Write-without-read entries become regions shared between machine mode and lower modes. A locked all-ones entry becomes a shared read-only region. Every other locked entry applies only to machine mode, and every other unlocked entry applies only to lower modes. When nothing matches, lower modes are denied, and machine mode is governed by the two policy bits. The default-deny bit wins over lockdown.

The gate is purely combinational and holds no state. The decision is valid in the same cycle as its inputs.

Top module: `pmpck_gate`

## Requirements
- R1: `acc_kind` encodes the access as 2'b00 read, 2'b01 write and 2'b10 execute. The code 2'b11 is a no-access code and always yields `grant` = 0.
- R2: With `entry_hit`=1 and `lockdown_en`=0, a machine-mode access to an entry with `entry_l`=0 is granted whatever its R/W/X bits are.
- R3: With `entry_hit`=1 and `lockdown_en`=0, a lower-mode access, or a machine-mode access to an entry with `entry_l`=1, is granted exactly when the entry bit for that access type is set.
- R4: With lockdown on and an entry of R=0, W=1, L=1: execute is granted in every mode, read is granted only in machine mode and only when X=1, and write is denied.
- R5: With lockdown on and an entry of R=0, W=1, L=0: read is granted in every mode, write is granted when the mode is machine or X=1, and execute is denied.
- R6: With lockdown on and an entry of R=W=X=1, L=1: read is granted in every mode, and write and execute are denied.
- R7: With lockdown on, any other entry grants an access only when `priv_machine` equals `entry_l` and the entry bit for that access type is set.
- R8: With `entry_hit`=0, a lower-mode access is always denied.
- R9: With `entry_hit`=0 and `default_deny`=1, machine-mode accesses of every type are denied, whatever `lockdown_en` is.
- R10: With `entry_hit`=0 and `default_deny`=0, machine-mode read and write are granted. Machine-mode execute is granted only when `lockdown_en`=0.
- R11: With `entry_hit`=0, the entry bits R, W, X and L have no effect on `grant`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| entry_hit | input | 1 | An entry matched the access |
| entry_r | input | 1 | Read permission of the matched entry |
| entry_w | input | 1 | Write permission of the matched entry |
| entry_x | input | 1 | Execute permission of the matched entry |
| entry_l | input | 1 | Lock bit of the matched entry |
| acc_kind | input | 2 | Access type code (see R1) |
| priv_machine | input | 1 | Effective privilege is machine mode |
| lockdown_en | input | 1 | Machine-mode lockdown policy bit |
| default_deny | input | 1 | Deny machine mode when no entry matches |
| grant | output | 1 | Access allowed |

## Verification
Immediate assertions re-evaluate whenever the inputs change. They cover the no-access code, the unlocked machine-mode bypass, the write-deny and read-only rules of the shared lockdown regions, the mode mismatch of plain lockdown entries, and the denials in the no-match path. The exact grant value for every combination, including the cases where permission follows X or the privilege, cannot be shown by these properties. Neither can the fact that entry bits have no effect when nothing matched. The bench shows these through its directed scenarios and a full sweep of all 1024 input combinations, compared against its own model of the rules.

// File: rtl/pmpck_pkg.sv
package pmpck_pkg;

  localparam int ACC_W = 2;

  typedef enum logic [ACC_W-1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EXEC  = 2'b10,
    ACC_NONE  = 2'b11
  } acc_e;

  typedef struct packed {
    logic l;
    logic x;
    logic w;
    logic r;
  } perm_t;

  typedef enum logic [1:0] {
    LD_SHARED_LOCKED = 2'd0,
    LD_SHARED_OPEN   = 2'd1,
    LD_READONLY      = 2'd2,
    LD_PLAIN         = 2'd3
  } ld_class_e;

  // Select the entry bit matching the access type.
  function automatic logic rwx_grant(perm_t p, acc_e a);
    logic g;
    case (a)
      ACC_READ:  g = p.r;
      ACC_WRITE: g = p.w;
      ACC_EXEC:  g = p.x;
      default:   g = 1'b0;
    endcase
    return g;
  endfunction

  // Classify an entry under lockdown.
  function automatic ld_class_e ld_classify(perm_t p);
    ld_class_e c;
    if (!p.r && p.w)
      c = p.l ? LD_SHARED_LOCKED : LD_SHARED_OPEN;
    else if (p.r && p.w && p.x && p.l)
      c = LD_READONLY;
    else
      c = LD_PLAIN;
    return c;
  endfunction

  // Grant for a shared locked region: execute everywhere, machine read when X set.
  function automatic logic shared_locked_grant(perm_t p, acc_e a, logic pm);
    logic g;
    case (a)
      ACC_EXEC: g = 1'b1;
      ACC_READ: g = pm & p.x;
      default:  g = 1'b0;
    endcase
    return g;
  endfunction

  // Grant for a shared open region: read everywhere, write for machine or X.
  function automatic logic shared_open_grant(perm_t p, acc_e a, logic pm);
    logic g;
    case (a)
      ACC_READ:  g = 1'b1;
      ACC_WRITE: g = pm | p.x;
      default:   g = 1'b0;
    endcase
    return g;
  endfunction

  // No-match default for machine mode.
  function automatic logic nomatch_machine_grant(acc_e a, logic ld, logic dd);
    logic g;
    if (dd)
      g = 1'b0;
    else if (ld)
      g = (a == ACC_READ) || (a == ACC_WRITE);
    else
      g = (a != ACC_NONE);
    return g;
  endfunction

endpackage

// File: rtl/pmpck_legacy_rule.sv
module pmpck_legacy_rule
  import pmpck_pkg::*;
(
  input  perm_t perm_i,
  input  acc_e  acc_i,
  input  logic  priv_m_i,
  output logic  grant_o
);

  logic bypass_m;
  logic bits_ok;

  assign bypass_m = priv_m_i && !perm_i.l;
  assign bits_ok  = rwx_grant(perm_i, acc_i);

  always_comb begin
    if (acc_i == ACC_NONE)
      grant_o = 1'b0;
    else if (bypass_m)
      grant_o = 1'b1;
    else
      grant_o = bits_ok;
  end

  always_comb begin
    if (priv_m_i && !perm_i.l && acc_i != ACC_NONE)
      assert_unlocked_machine_bypass_R2: assert (grant_o == 1'b1);
    if (!priv_m_i)
      assert_lower_follows_bits_R3: assert (grant_o == (bits_ok && acc_i != ACC_NONE));
  end

endmodule

// File: rtl/pmpck_lockdown_rule.sv
module pmpck_lockdown_rule
  import pmpck_pkg::*;
(
  input  perm_t     perm_i,
  input  acc_e      acc_i,
  input  logic      priv_m_i,
  output ld_class_e class_o,
  output logic      grant_o
);

  logic mode_match;
  logic bits_ok;
  logic g_sl, g_so;

  assign class_o    = ld_classify(perm_i);
  assign mode_match = (priv_m_i == perm_i.l);
  assign bits_ok    = rwx_grant(perm_i, acc_i);
  assign g_sl       = shared_locked_grant(perm_i, acc_i, priv_m_i);
  assign g_so       = shared_open_grant(perm_i, acc_i, priv_m_i);

  always_comb begin
    unique case (class_o)
      LD_SHARED_LOCKED: grant_o = g_sl;
      LD_SHARED_OPEN:   grant_o = g_so;
      LD_READONLY:      grant_o = (acc_i == ACC_READ);
      default:          grant_o = mode_match & bits_ok;
    endcase
  end

  always_comb begin
    if (!perm_i.r && perm_i.w && perm_i.l && acc_i == ACC_WRITE)
      assert_shared_locked_no_write_R4: assert (!grant_o);
    if (!perm_i.r && perm_i.w && !perm_i.l && acc_i == ACC_EXEC)
      assert_shared_open_no_exec_R5: assert (!grant_o);
    if (perm_i.r && perm_i.w && perm_i.x && perm_i.l)
      assert_readonly_region_R6: assert (grant_o == (acc_i == ACC_READ));
    if (class_o == LD_PLAIN && priv_m_i != perm_i.l)
      assert_mode_mismatch_deny_R7: assert (!grant_o);
  end

endmodule

// File: rtl/pmpck_default_rule.sv
module pmpck_default_rule
  import pmpck_pkg::*;
(
  input  acc_e acc_i,
  input  logic priv_m_i,
  input  logic lockdown_i,
  input  logic deny_i,
  output logic grant_o
);

  logic m_grant;

  assign m_grant = nomatch_machine_grant(acc_i, lockdown_i, deny_i);
  assign grant_o = priv_m_i & m_grant;

  always_comb begin
    if (!priv_m_i)
      assert_nomatch_lower_deny_R8: assert (!grant_o);
    if (deny_i)
      assert_default_deny_all_R9: assert (!grant_o);
    if (priv_m_i && !deny_i && (acc_i == ACC_READ || acc_i == ACC_WRITE))
      assert_nomatch_machine_rw_R10: assert (grant_o);
  end

endmodule

// File: rtl/pmpck_gate.sv
module pmpck_gate
  import pmpck_pkg::*;
(
  input  logic             entry_hit,
  input  logic             entry_r,
  input  logic             entry_w,
  input  logic             entry_x,
  input  logic             entry_l,
  input  logic [ACC_W-1:0] acc_kind,
  input  logic             priv_machine,
  input  logic             lockdown_en,
  input  logic             default_deny,
  output logic             grant
);

  perm_t     perm;
  acc_e      acc;
  ld_class_e ld_class;
  logic      grant_legacy;
  logic      grant_ld;
  logic      grant_miss;

  assign perm = '{l: entry_l, x: entry_x, w: entry_w, r: entry_r};
  assign acc  = acc_e'(acc_kind);

  pmpck_legacy_rule u_legacy (
    .perm_i   (perm),
    .acc_i    (acc),
    .priv_m_i (priv_machine),
    .grant_o  (grant_legacy)
  );

  pmpck_lockdown_rule u_lockdown (
    .perm_i   (perm),
    .acc_i    (acc),
    .priv_m_i (priv_machine),
    .class_o  (ld_class),
    .grant_o  (grant_ld)
  );

  pmpck_default_rule u_default (
    .acc_i      (acc),
    .priv_m_i   (priv_machine),
    .lockdown_i (lockdown_en),
    .deny_i     (default_deny),
    .grant_o    (grant_miss)
  );

  always_comb begin
    if (acc == ACC_NONE)
      grant = 1'b0;
    else if (!entry_hit)
      grant = grant_miss;
    else if (lockdown_en)
      grant = grant_ld;
    else
      grant = grant_legacy;
  end

  always_comb begin
    if (acc_kind == 2'b11)
      assert_no_access_code_R1: assert (!grant);
    if (!entry_hit && !priv_machine)
      assert_miss_lower_port_R8: assert (!grant);
    if (entry_hit && lockdown_en && ld_class == LD_SHARED_LOCKED && acc == ACC_EXEC)
      assert_shared_exec_port_R4: assert (grant);
  end

endmodule

// File: tb/tb_pmpck_gate.sv
module tb_pmpck_gate;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       entry_hit, entry_r, entry_w, entry_x, entry_l;
  logic [1:0] acc_kind;
  logic       priv_machine, lockdown_en, default_deny;
  logic       grant;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  pmpck_gate dut (
    .entry_hit    (entry_hit),
    .entry_r      (entry_r),
    .entry_w      (entry_w),
    .entry_x      (entry_x),
    .entry_l      (entry_l),
    .acc_kind     (acc_kind),
    .priv_machine (priv_machine),
    .lockdown_en  (lockdown_en),
    .default_deny (default_deny),
    .grant        (grant)
  );

  // Independent model, written from the requirement text.
  function automatic bit model(bit h, bit r, bit w, bit x, bit l,
                               bit [1:0] a, bit pm, bit ld, bit dd);
    bit want;
    if (a == 2'b11) return 1'b0;
    if (!h) begin
      if (!pm || dd) return 1'b0;
      return ld ? (a != 2'b10) : 1'b1;
    end
    want = (a == 2'b00) ? r : ((a == 2'b01) ? w : x);
    if (!ld) return (pm && !l) ? 1'b1 : want;
    if (w && !r) begin
      if (l) return (a == 2'b10) || (a == 2'b00 && pm && x);
      return (a == 2'b00) || (a == 2'b01 && (pm || x));
    end
    if (r && w && x && l) return a == 2'b00;
    return (pm == l) && want;
  endfunction

  function automatic string tag_of(bit h, bit r, bit w, bit x, bit l,
                                   bit [1:0] a, bit pm, bit ld, bit dd);
    if (a == 2'b11) return "R1";
    if (!h) return !pm ? "R8" : (dd ? "R9" : "R10");
    if (!ld) return (pm && !l) ? "R2" : "R3";
    if (w && !r) return l ? "R4" : "R5";
    if (r && w && x && l) return "R6";
    return "R7";
  endfunction

  task automatic drive(bit h, bit r, bit w, bit x, bit l,
                       bit [1:0] a, bit pm, bit ld, bit dd);
    @(posedge clk);
    entry_hit = h; entry_r = r; entry_w = w; entry_x = x; entry_l = l;
    acc_kind = a; priv_machine = pm; lockdown_en = ld; default_deny = dd;
    @(negedge clk);
  endtask

  task automatic check(string tag, bit exp);
    n_checks++;
    if (grant !== exp) begin
      n_fails++;
      $display("FAIL %s: grant=%b expected=%b (hit=%b r=%b w=%b x=%b l=%b acc=%b m=%b ld=%b dd=%b)",
               tag, grant, exp, entry_hit, entry_r, entry_w, entry_x, entry_l,
               acc_kind, priv_machine, lockdown_en, default_deny);
    end
  endtask

  task automatic t_reset_state;
    drive(0, 0, 0, 0, 0, 2'b00, 1, 0, 0);
    check("R10 initial all-clear machine read", 1'b1);
  endtask

  task automatic t_no_access_code;
    drive(1, 1, 1, 1, 0, 2'b11, 1, 0, 0);
    check("R1 no-access code machine", 1'b0);
    drive(0, 0, 0, 0, 0, 2'b11, 1, 0, 0);
    check("R1 no-access code miss", 1'b0);
  endtask

  task automatic t_legacy;
    drive(1, 0, 0, 0, 0, 2'b01, 1, 0, 0);
    check("R2 unlocked machine write", 1'b1);
    drive(1, 1, 0, 0, 1, 2'b01, 1, 0, 0);
    check("R3 locked machine write denied", 1'b0);
    drive(1, 0, 0, 1, 0, 2'b10, 0, 0, 0);
    check("R3 lower exec allowed", 1'b1);
  endtask

  task automatic t_shared_locked;
    drive(1, 0, 1, 0, 1, 2'b10, 0, 1, 0);
    check("R4 lower exec", 1'b1);
    drive(1, 0, 1, 1, 1, 2'b00, 1, 1, 0);
    check("R4 machine read X=1", 1'b1);
    drive(1, 0, 1, 0, 1, 2'b00, 1, 1, 0);
    check("R4 machine read X=0", 1'b0);
    drive(1, 0, 1, 1, 1, 2'b01, 1, 1, 0);
    check("R4 write denied", 1'b0);
  endtask

  task automatic t_shared_open;
    drive(1, 0, 1, 0, 0, 2'b00, 0, 1, 0);
    check("R5 lower read", 1'b1);
    drive(1, 0, 1, 0, 0, 2'b01, 0, 1, 0);
    check("R5 lower write X=0", 1'b0);
    drive(1, 0, 1, 1, 0, 2'b01, 0, 1, 0);
    check("R5 lower write X=1", 1'b1);
    drive(1, 0, 1, 1, 0, 2'b10, 1, 1, 0);
    check("R5 exec denied", 1'b0);
  endtask

  task automatic t_readonly;
    drive(1, 1, 1, 1, 1, 2'b00, 0, 1, 0);
    check("R6 lower read", 1'b1);
    drive(1, 1, 1, 1, 1, 2'b01, 1, 1, 0);
    check("R6 machine write", 1'b0);
  endtask

  task automatic t_plain;
    drive(1, 1, 0, 1, 1, 2'b10, 1, 1, 0);
    check("R7 locked machine exec", 1'b1);
    drive(1, 1, 0, 1, 1, 2'b00, 0, 1, 0);
    check("R7 locked lower read denied", 1'b0);
    drive(1, 1, 0, 0, 0, 2'b00, 1, 1, 0);
    check("R7 unlocked machine read denied", 1'b0);
  endtask

  task automatic t_nomatch;
    drive(0, 0, 0, 0, 0, 2'b00, 0, 0, 0);
    check("R8 lower miss read", 1'b0);
    drive(0, 0, 0, 0, 0, 2'b00, 1, 1, 1);
    check("R9 deny over lockdown", 1'b0);
    drive(0, 0, 0, 0, 0, 2'b10, 1, 1, 0);
    check("R10 lockdown miss exec", 1'b0);
    drive(0, 0, 0, 0, 0, 2'b01, 1, 1, 0);
    check("R10 lockdown miss write", 1'b1);
  endtask

  task automatic t_ignore_entry_bits;
    for (int a = 0; a < 3; a++) begin
      for (int pol = 0; pol < 8; pol++) begin
        bit ref_g;
        drive(0, 0, 0, 0, 0, 2'(a), pol[0], pol[1], pol[2]);
        ref_g = grant;
        for (int b = 1; b < 16; b++) begin
          drive(0, b[0], b[1], b[2], b[3], 2'(a), pol[0], pol[1], pol[2]);
          check("R11 entry bits on miss", ref_g);
        end
      end
    end
  endtask

  task automatic t_sweep;
    for (int v = 0; v < 1024; v++) begin
      drive(v[0], v[1], v[2], v[3], v[4], v[6:5], v[7], v[8], v[9]);
      check(tag_of(v[0], v[1], v[2], v[3], v[4], v[6:5], v[7], v[8], v[9]),
            model(v[0], v[1], v[2], v[3], v[4], v[6:5], v[7], v[8], v[9]));
    end
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    entry_hit = 0; entry_r = 0; entry_w = 0; entry_x = 0; entry_l = 0;
    acc_kind = 2'b00; priv_machine = 1; lockdown_en = 0; default_deny = 0;
    t_reset_state();
    t_no_access_code();
    t_legacy();
    t_shared_locked();
    t_shared_open();
    t_readonly();
    t_plain();
    t_nomatch();
    t_ignore_entry_bits();
    t_sweep();
    finish_run();
  end

  initial begin
    #(4 * 200000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

endmodule